// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block sits beside a page-table walker and keeps the record of the most recent translation fault. Each time the walker reports a fault, the block stores the faulting virtual address and builds a status word. The status word carries the walk level at which the fault occurred, the fault type, the kind of access that was attempted, a flag marking the stored address as valid, and an overflow flag. Software reads both words through a small registered read port. Reading the status word clears it, so that the next fault starts a fresh record.

A three-state machine follows the life of the record:

- `ST_CLEAR` means no fault is recorded.
- `ST_LOGGED` means one fault is unread.
- `ST_OVERRUN` means a further fault arrived before the status was read.

The transitions are:

- `ST_CLEAR` goes to `ST_LOGGED` on a fault.
- `ST_LOGGED` goes to `ST_OVERRUN` on a fault.
- `ST_OVERRUN` stays in `ST_OVERRUN` on a fault.
- `ST_LOGGED` and `ST_OVERRUN` go back to `ST_CLEAR` on a status read that comes in a cycle with no fault.

A status read in `ST_CLEAR` stays in `ST_CLEAR`.

On every fault the block also asks for a trap. An instruction fetch leads to an instruction-fault request and any other access leads to a data-fault request. The request is dropped entirely while the no-fault control is set or while traps are disabled.

Top module: `mmu_fault_recorder`

## Requirements
- R1: After reset the following are all zero: the status word, the fault address, read data, `itrap_req` and `dtrap_req`. Both trap outputs also stay zero in every cycle that follows a cycle without a fault.
- R2: A fault recorded into an empty status gives a status word with these fields:
  - bits [9:8] hold the walk level;
  - bits [7:5] hold the 3-bit access index;
  - bits [4:2] hold the fault type;
  - bit 1 is set (address valid);
  - bit 0 is clear (no overflow);
  - every higher bit is zero.
- R3: A fault that arrives while the status word is nonzero replaces it with 1, and then the new fault's fields and bit 1 are merged in. The result is 1 | 2 | new fields, and the earlier fields are lost. Further faults keep bit 0 set.
- R4: Every fault loads the full faulting virtual address into the address register. That register is read with `rd_sel`=1.
- R5: A read with `rd_en`=1 and `rd_sel`=0 returns the status word on `rd_data` one cycle later, and the status reads as zero from the following cycle on. `rd_data` holds its value while `rd_en`=0.
- R6: Reading the address register (`rd_sel`=1) leaves the status word unchanged.
- R7: When a fault and a read come in the same cycle, the fault is recorded. If the status was nonzero it is recorded with overflow, and a status read does not clear it. The read returns the value held before that cycle.
- R8: Access index bit 1 marks an instruction fetch. A fault with that bit set raises `itrap_req` for exactly one cycle, in the cycle after the fault. Any other fault raises `dtrap_req` in the same way. The two requests are never high together.
- R9: While `ctl_no_fault`=1 or `ctl_trap_en`=0, a fault raises no trap request. The status word and the address are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flt_valid | input | 1 | Walker reports a fault this cycle |
| flt_level | input | 2 | Walk level at which the fault occurred |
| flt_type | input | 3 | Fault type code from the walker |
| flt_access | input | 3 | Access index; bit 1 set means instruction fetch |
| flt_vaddr | input | VA_W | Faulting virtual address |
| ctl_no_fault | input | 1 | No-fault mode: suppress trap requests |
| ctl_trap_en | input | 1 | Traps enabled; 0 suppresses trap requests |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects the status word, 1 selects the fault address |
| rd_data | output | DATA_W | Registered read data |
| itrap_req | output | 1 | One-cycle instruction-fault trap request |
| dtrap_req | output | 1 | One-cycle data-fault trap request |

## Verification
The hardest situation to reach is the collision between a fault and a status read in the same cycle. In that cycle the read must return the old word while the new fault is merged, and in the overflow form the merged result depends on whether the old word was zero. The bench reaches both forms on purpose. It records a first fault, then drives the second fault in the same cycle as the read strobe. It also repeats the collision from an empty record. Each time it follows with a plain status read that exposes the merged word and shows whether overflow was applied.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

    localparam int STAT_W    = 10;
    localparam int FETCH_BIT = 1;
    localparam logic SEL_STATUS = 1'b0;

    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,
        ST_LOGGED  = 2'd1,
        ST_OVERRUN = 2'd2
    } rec_state_t;

    typedef struct packed {
        logic [1:0] level;
        logic [2:0] acc;
        logic [2:0] kind;
    } fault_fields_t;

    // Status layout: level [9:8], access [7:5], type [4:2], valid [1], overflow [0]
    function automatic logic [STAT_W-1:0] pack_status(fault_fields_t f, logic vld, logic ovf);
        return {f.level, f.acc, f.kind, vld, ovf};
    endfunction

endpackage

// File: rtl/mfr_state_fsm.sv
module mfr_state_fsm
    import mfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_i,
    input  logic       clear_i,
    output rec_state_t state_o,
    output logic       valid_o,
    output logic       ovf_o
);

    rec_state_t state_q, state_d;

    // next-state selection; a fault always wins over a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (fault_i) state_d = ST_LOGGED;
            end
            ST_LOGGED: begin
                if (fault_i)      state_d = ST_OVERRUN;
                else if (clear_i) state_d = ST_CLEAR;
            end
            ST_OVERRUN: begin
                if (fault_i)      state_d = ST_OVERRUN;
                else if (clear_i) state_d = ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o = state_q;
        valid_o = (state_q != ST_CLEAR);
        ovf_o   = (state_q == ST_OVERRUN);
    end

endmodule

// File: rtl/mfr_capture.sv
module mfr_capture
    import mfr_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_i,
    input  logic          clear_i,
    input  fault_fields_t fields_i,
    input  logic [VA_W-1:0] vaddr_i,
    output fault_fields_t fields_o,
    output logic [VA_W-1:0] addr_o
);

    fault_fields_t   fields_q;
    logic [VA_W-1:0] addr_q;

    // the newest fault replaces the fields; an overrun keeps no older ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fields_q <= '0;
        else if (fault_i) fields_q <= fields_i;
        else if (clear_i) fields_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr_q <= '0;
        else if (fault_i) addr_q <= vaddr_i;
    end

    assign fields_o = fields_q;
    assign addr_o   = addr_q;

endmodule

// File: rtl/mfr_trap_sel.sv
module mfr_trap_sel
    import mfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_i,
    input  logic [2:0] acc_i,
    input  logic       no_fault_i,
    input  logic       trap_en_i,
    output logic       itrap_o,
    output logic       dtrap_o
);

    logic allow;
    logic fetch;
    logic itrap_q, dtrap_q;

    always_comb begin
        allow = fault_i && !no_fault_i && trap_en_i;
        fetch = acc_i[FETCH_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            itrap_q <= 1'b0;
            dtrap_q <= 1'b0;
        end else begin
            itrap_q <= allow && fetch;
            dtrap_q <= allow && !fetch;
        end
    end

    assign itrap_o = itrap_q;
    assign dtrap_o = dtrap_q;

endmodule

// File: rtl/mfr_read_port.sv
module mfr_read_port
    import mfr_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              rd_sel_i,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [VA_W-1:0]   addr_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] mux;

    always_comb begin
        if (rd_sel_i == SEL_STATUS) mux = DATA_W'(stat_i);
        else                        mux = DATA_W'(addr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_en_i) data_q <= mux;
    end

    assign data_o = data_q;

endmodule

// File: rtl/mmu_fault_recorder.sv
module mmu_fault_recorder
    import mfr_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [1:0]        flt_level,
    input  logic [2:0]        flt_type,
    input  logic [2:0]        flt_access,
    input  logic [VA_W-1:0]   flt_vaddr,
    input  logic              ctl_no_fault,
    input  logic              ctl_trap_en,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              itrap_req,
    output logic              dtrap_req
);

    rec_state_t        rec_state;
    logic              rec_valid;
    logic              rec_ovf;
    logic              stat_clear;
    fault_fields_t     in_fields;
    fault_fields_t     held_fields;
    logic [VA_W-1:0]   addr_q;
    logic [STAT_W-1:0] stat_word;

    always_comb begin
        stat_clear      = rd_en && (rd_sel == SEL_STATUS);
        in_fields.level = flt_level;
        in_fields.acc   = flt_access;
        in_fields.kind  = flt_type;
        stat_word       = pack_status(held_fields, rec_valid, rec_ovf);
    end

    mfr_state_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (flt_valid),
        .clear_i (stat_clear),
        .state_o (rec_state),
        .valid_o (rec_valid),
        .ovf_o   (rec_ovf)
    );

    mfr_capture #(.VA_W(VA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (flt_valid),
        .clear_i  (stat_clear),
        .fields_i (in_fields),
        .vaddr_i  (flt_vaddr),
        .fields_o (held_fields),
        .addr_o   (addr_q)
    );

    mfr_trap_sel u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_i    (flt_valid),
        .acc_i      (flt_access),
        .no_fault_i (ctl_no_fault),
        .trap_en_i  (ctl_trap_en),
        .itrap_o    (itrap_req),
        .dtrap_o    (dtrap_req)
    );

    mfr_read_port #(.VA_W(VA_W), .DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (rd_en),
        .rd_sel_i (rd_sel),
        .stat_i   (stat_word),
        .addr_i   (addr_q),
        .data_o   (rd_data)
    );

endmodule

// File: rtl/mfr_checker.sv
module mfr_checker
    import mfr_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_valid,
    input logic [2:0]        flt_access,
    input logic [VA_W-1:0]   flt_vaddr,
    input logic              ctl_no_fault,
    input logic              ctl_trap_en,
    input logic              rd_en,
    input logic              rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              itrap_req,
    input logic              dtrap_req,
    input logic [STAT_W-1:0] stat_word,
    input logic [VA_W-1:0]   addr_q
);

    a_r2_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> stat_word[1]);

    a_r3_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && (stat_word != '0)) |=> stat_word[0]);

    a_r4_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> (addr_q == $past(flt_vaddr)));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && !flt_valid) |=> (stat_word == '0));

    a_r6_addr_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel && !flt_valid) |=> $stable(stat_word));

    a_r7_read_old_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel) |=> (rd_data == DATA_W'($past(stat_word))));

    a_r8_fetch_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !ctl_no_fault && ctl_trap_en && flt_access[FETCH_BIT]) |=> (itrap_req && !dtrap_req));

    a_r8_data_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !ctl_no_fault && ctl_trap_en && !flt_access[FETCH_BIT]) |=> (dtrap_req && !itrap_req));

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_valid || ctl_no_fault || !ctl_trap_en) |=> (!itrap_req && !dtrap_req));

endmodule

bind mmu_fault_recorder mfr_checker #(.VA_W(VA_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_valid    (flt_valid),
    .flt_access   (flt_access),
    .flt_vaddr    (flt_vaddr),
    .ctl_no_fault (ctl_no_fault),
    .ctl_trap_en  (ctl_trap_en),
    .rd_en        (rd_en),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .itrap_req    (itrap_req),
    .dtrap_req    (dtrap_req),
    .stat_word    (stat_word),
    .addr_q       (addr_q)
);

// File: tb/test_mmu_fault_recorder.sv
module test_mmu_fault_recorder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic [1:0]  flt_level = '0;
    logic [2:0]  flt_type = '0;
    logic [2:0]  flt_access = '0;
    logic [31:0] flt_vaddr = '0;
    logic        ctl_no_fault = 1'b0;
    logic        ctl_trap_en = 1'b1;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        itrap_req;
    logic        dtrap_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mmu_fault_recorder i_mmu_fault_recorder (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_level(flt_level),
        .flt_type(flt_type), .flt_access(flt_access), .flt_vaddr(flt_vaddr),
        .ctl_no_fault(ctl_no_fault), .ctl_trap_en(ctl_trap_en), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .itrap_req(itrap_req), .dtrap_req(dtrap_req)
    );

    function automatic logic [31:0] exp_stat(logic ovf, logic [1:0] lv, logic [2:0] ac, logic [2:0] ty);
        return 32'(ovf) + 32'd2 + (32'(ty) << 2) + (32'(ac) << 5) + (32'(lv) << 8);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, return at the next negedge with results visible
    task automatic cyc(logic f, logic [1:0] lv, logic [2:0] ty, logic [2:0] ac, logic [31:0] va,
                       logic rd, logic sel);
        flt_valid = f; flt_level = lv; flt_type = ty; flt_access = ac; flt_vaddr = va;
        rd_en = rd; rd_sel = sel;
        @(negedge clk);
        flt_valid = 1'b0; rd_en = 1'b0;
    endtask

    task automatic fault(logic [1:0] lv, logic [2:0] ty, logic [2:0] ac, logic [31:0] va);
        cyc(1'b1, lv, ty, ac, va, 1'b0, 1'b0);
    endtask

    task automatic rd(logic sel);
        cyc(1'b0, 2'd0, 3'd0, 3'd0, 32'd0, 1'b1, sel);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'd0);
        chk("R1 itrap", {31'd0, itrap_req}, 32'd0);
        chk("R1 dtrap", {31'd0, dtrap_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0); chk("R1 status after reset", rd_data, 32'd0);
        rd(1'b1); chk("R1 address after reset", rd_data, 32'd0);

        // R2/R4/R5/R6/R8 sweep over all fields
        for (int i = 0; i < 256; i++) begin
            logic [1:0]  lv = i[7:6];
            logic [2:0]  ty = i[5:3];
            logic [2:0]  ac = i[2:0];
            logic [31:0] va = 32'hA500_0000 ^ (i * 32'h0001_0F3D);
            fault(lv, ty, ac, va);
            chk("R8 itrap", {31'd0, itrap_req}, {31'd0, ac[1]});
            chk("R8 dtrap", {31'd0, dtrap_req}, {31'd0, !ac[1]});
            rd(1'b1);
            chk("R4 address", rd_data, va);
            chk("R8 one-cycle pulse", {30'd0, itrap_req, dtrap_req}, 32'd0);
            rd(1'b0);
            chk("R2/R6 status layout", rd_data, exp_stat(1'b0, lv, ac, ty));
            rd(1'b0);
            chk("R5 cleared", rd_data, 32'd0);
            chk("R1 idle no trap", {30'd0, itrap_req, dtrap_req}, 32'd0);
        end

        // R3 overflow: earlier fields lost, newest kept, bit0 set
        for (int i = 0; i < 32; i++) begin
            logic [1:0] la = i[1:0];      logic [2:0] ta = i[4:2];     logic [2:0] aa = 3'(i * 3);
            logic [1:0] lb = 2'(~i);      logic [2:0] tb = 3'(i + 5);  logic [2:0] ab = 3'(i ^ 6);
            fault(la, ta, aa, 32'h1000 + 32'(i));
            fault(lb, tb, ab, 32'h8000_0000 + 32'(i));
            if (i % 4 == 0) fault(lb, tb, ab, 32'h8000_0000 + 32'(i));
            rd(1'b0);
            chk("R3 overflow merge", rd_data, exp_stat(1'b1, lb, ab, tb));
            rd(1'b1);
            chk("R3/R4 newest address", rd_data, 32'h8000_0000 + 32'(i));
            rd(1'b0);
            chk("R3/R5 cleared after overflow", rd_data, 32'd0);
        end

        // R7 collision with a held record
        fault(2'd1, 3'd4, 3'd2, 32'hCAFE_0000);
        cyc(1'b1, 2'd3, 3'd1, 3'd5, 32'hBEEF_0004, 1'b1, 1'b0);
        chk("R7 read returns old", rd_data, exp_stat(1'b0, 2'd1, 3'd2, 3'd4));
        rd(1'b0);
        chk("R7 fault kept with overflow", rd_data, exp_stat(1'b1, 2'd3, 3'd5, 3'd1));
        rd(1'b0);
        chk("R7 then cleared", rd_data, 32'd0);
        // R7 collision from empty
        cyc(1'b1, 2'd2, 3'd6, 3'd3, 32'h0000_F00D, 1'b1, 1'b0);
        chk("R7 read returns empty", rd_data, 32'd0);
        rd(1'b0);
        chk("R7 fault kept no overflow", rd_data, exp_stat(1'b0, 2'd2, 3'd3, 3'd6));
        // R7 collision with an address read
        fault(2'd0, 3'd2, 3'd0, 32'h1111_2222);
        cyc(1'b1, 2'd0, 3'd2, 3'd0, 32'h3333_4444, 1'b1, 1'b1);
        chk("R7 address read old", rd_data, 32'h1111_2222);
        rd(1'b1);
        chk("R7 address new", rd_data, 32'h3333_4444);
        rd(1'b0); rd(1'b0);

        // R9 masking combinations
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 8; a++) begin
                logic allow;
                ctl_no_fault = m[0];
                ctl_trap_en  = m[1];
                allow = !m[0] && m[1];
                fault(2'(a), 3'(7 - a), 3'(a), 32'h7700_0000 + 32'(a));
                chk("R9 itrap", {31'd0, itrap_req}, {31'd0, allow && a[1]});
                chk("R9 dtrap", {31'd0, dtrap_req}, {31'd0, allow && !a[1]});
                rd(1'b0);
                chk("R9 still recorded", rd_data, exp_stat(1'b0, 2'(a), 3'(a), 3'(7 - a)));
            end
        end
        ctl_no_fault = 1'b0; ctl_trap_en = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule